// File: doc/BRIEF.md
# Complement-Shadowed Memory with Switchover Request

This block is a synchronous single-port RAM that keeps two copies of every word. One array holds the data as written. A second array, at the same address, holds the bit-wise complement. A write fills both arrays in the same clock edge. A read fetches both words in the same cycle. The complement copy is inverted back and compared bit by bit with the true copy. The true word is returned with the one-cycle latency of an ordinary synchronous RAM. Any disagreement raises a mismatch flag next to the read data. Because the two arrays never hold the same stored value, a fault that drives the same bit of both arrays to one level is still caught.

A mismatch moves a small two-state controller from ARMED to TRIPPED. The transition TRIP is taken on a flagged read. In TRIPPED the switchover request output is held high, and the address of the failing read is kept. The transition HOLD keeps the controller in TRIPPED on every cycle without a clear. RELEASE returns it to ARMED when the clear input is high and no mismatch is present. RETRIP keeps it in TRIPPED and stores the new failing address when a clear coincides with a fresh mismatch. A fault-injection port lets a test corrupt one bit of a stored word. It can flip the bit in either array, flip it in both, or force it to a given level in both. Reading a word that has never been written returns undefined data.

Top module: `twin_complement_ram`

## Requirements
- R1: A write (req_en=1, req_we=1) stores req_wdata in the true array and ~req_wdata in the shadow array in the same cycle. A later read of that address returns the written word on rd_data, with rd_mismatch low.
- R2: When req_en=1 and req_we=0 in cycle N, rd_data, rd_valid=1 and rd_mismatch are presented in cycle N+1. rd_valid is 0 in any cycle that does not follow a read. rd_data holds its value until the next read.
- R3: A single inverted bit at any bit position, in either the true or the shadow copy of a word, sets rd_mismatch when that word is read. rd_data always carries the true copy.
- R4: A read with rd_mismatch=1 sets switch_req in the next cycle (TRIP) and loads that read's address into fail_addr. Without a mismatch, switch_req never rises.
- R5: switch_req stays high until switch_clr=1 is applied in a cycle with no mismatch (RELEASE). switch_clr has no effect while in ARMED.
- R6: While in TRIPPED, fail_addr keeps the first failing address, even when further reads, clean or mismatching, occur (HOLD).
- R7: When switch_clr=1 coincides with a mismatching read, switch_req stays high and fail_addr takes the new failing address (RETRIP).
- R8: bd_mode=2 forces bit bd_bit of the word at bd_addr to bd_value in both arrays. This common-mode fault is detected on read whichever level is forced.
- R9: bd_mode=3 flips the bit in both arrays. The read then returns the flipped bit with rd_mismatch low, because the shadow copy remains the exact complement. bd_mode=0 flips the true copy only; bd_mode=1 flips the shadow copy only.
- R10: An injection (bd_en=1) is ignored when a write to the same address occurs in the same cycle. The written word is stored intact in both arrays.
- R11: After reset the controller is ARMED, and switch_req, fail_addr, rd_valid and rd_mismatch are all 0.
- R12: Rewriting a word replaces both copies and removes any injected fault at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_en | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address, AW = clog2(DEPTH) |
| req_wdata | input | WIDTH | Write data |
| rd_data | output | WIDTH | True copy of the last word read |
| rd_valid | output | 1 | rd_data and rd_mismatch refer to a read issued in the previous cycle |
| rd_mismatch | output | 1 | The two copies of the word disagree |
| switch_clr | input | 1 | Clears a pending switchover request |
| switch_req | output | 1 | Sticky switchover request (state TRIPPED) |
| fail_addr | output | AW | Address of the read that tripped the request |
| bd_en | input | 1 | Fault injection strobe |
| bd_mode | input | 2 | 0 flip true, 1 flip shadow, 2 force both to bd_value, 3 flip both |
| bd_addr | input | AW | Word address of the injection |
| bd_bit | input | BW | Bit position of the injection, BW = clog2(WIDTH) |
| bd_value | input | 1 | Level forced in mode 2 |

## Verification
The round trip is tried with four data families: a multiplicative hash of the address, its complement, a walking one, and alternating all-ones/all-zeros words. Together they separate a lost inversion, a swapped address line and a stuck bit from correct storage. Every bit position is then corrupted in the true copy and then in the shadow copy. This shows whether the flag covers the full word and whether rd_data follows the true copy. Forced common-mode faults at both levels, and a flip of both copies, show that detection comes from the complement relation and not from plain equality. Sequences of clean and faulty reads around the clear input show apart the HOLD, RELEASE and RETRIP transitions and the first-address capture.

// File: rtl/tcr_pkg.sv
package tcr_pkg;

    typedef enum logic [0:0] {
        TRIP_ARMED   = 1'b0,
        TRIP_TRIPPED = 1'b1
    } trip_state_e;

    typedef enum logic [1:0] {
        INJ_FLIP_TRUE   = 2'd0,
        INJ_FLIP_SHADOW = 2'd1,
        INJ_FORCE_BOTH  = 2'd2,
        INJ_FLIP_BOTH   = 2'd3
    } inject_mode_e;

endpackage

// File: rtl/tcr_bank.sv
// One storage array of the pair. STORE_INVERTED selects whether the
// array keeps the written word or its complement.
module tcr_bank #(
    parameter int WIDTH          = 32,
    parameter int DEPTH          = 1024,
    parameter bit STORE_INVERTED = 1'b0,
    localparam int AW            = $clog2(DEPTH),
    localparam int BW            = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             acc_en,
    input  logic             acc_we,
    input  logic [AW-1:0]    acc_addr,
    input  logic [WIDTH-1:0] acc_wdata,
    input  logic             inj_flip,
    input  logic             inj_force,
    input  logic             inj_value,
    input  logic [AW-1:0]    inj_addr,
    input  logic [BW-1:0]    inj_bit,
    output logic [WIDTH-1:0] rd_word
);

    logic [WIDTH-1:0] cells [DEPTH];
    logic [WIDTH-1:0] phys_word;
    logic             do_write;
    logic             do_read;
    logic             inj_blocked;

    generate
        if (STORE_INVERTED) begin : g_inv
            assign phys_word = ~acc_wdata;
        end else begin : g_true
            assign phys_word = acc_wdata;
        end
    endgenerate

    assign do_write    = acc_en & acc_we;
    assign do_read     = acc_en & ~acc_we;
    // A write to the same word in the same cycle takes precedence.
    assign inj_blocked = do_write && (inj_addr == acc_addr);

    always_ff @(posedge clk) begin
        if (do_write) begin
            cells[acc_addr] <= phys_word;
        end
        if (!inj_blocked) begin
            if (inj_flip) begin
                cells[inj_addr][inj_bit] <= ~cells[inj_addr][inj_bit];
            end else if (inj_force) begin
                cells[inj_addr][inj_bit] <= inj_value;
            end
        end
        if (do_read) begin
            rd_word <= cells[acc_addr];
        end
    end

endmodule

// File: rtl/tcr_compare.sv
// Re-inverts the shadow word and compares it bit by bit with the true word.
module tcr_compare #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] true_word,
    input  logic [WIDTH-1:0] shadow_word,
    input  logic             check_en,
    output logic             mismatch
);

    logic [WIDTH-1:0] bit_bad;

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_bit
            // Healthy when the shadow bit is the complement of the true bit.
            assign bit_bad[g] = true_word[g] ~^ shadow_word[g];
        end
    endgenerate

    assign mismatch = check_en & (|bit_bad);

endmodule

// File: rtl/tcr_trip_fsm.sv
// Sticky switchover controller: ARMED -> TRIPPED on a mismatch.
module tcr_trip_fsm
    import tcr_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chk_fail,
    input  logic [AW-1:0] chk_addr,
    input  logic          clr,
    output logic          switch_req,
    output logic [AW-1:0] fail_addr
);

    trip_state_e state_q;
    trip_state_e state_d;
    logic        capture;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRIP_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            TRIP_ARMED: begin
                if (chk_fail) begin            // TRIP
                    state_d = TRIP_TRIPPED;
                    capture = 1'b1;
                end
            end
            TRIP_TRIPPED: begin
                if (clr) begin
                    if (chk_fail) begin        // RETRIP
                        capture = 1'b1;
                    end else begin             // RELEASE
                        state_d = TRIP_ARMED;
                    end
                end                            // else HOLD
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_addr <= '0;
        end else if (capture) begin
            fail_addr <= chk_addr;
        end
    end

    assign switch_req = (state_q == TRIP_TRIPPED);

endmodule

// File: rtl/twin_complement_ram.sv
module twin_complement_ram
    import tcr_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH),
    localparam int BW   = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_en,
    input  logic             req_we,
    input  logic [AW-1:0]    req_addr,
    input  logic [WIDTH-1:0] req_wdata,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             rd_mismatch,
    input  logic             switch_clr,
    output logic             switch_req,
    output logic [AW-1:0]    fail_addr,
    input  logic             bd_en,
    input  logic [1:0]       bd_mode,
    input  logic [AW-1:0]    bd_addr,
    input  logic [BW-1:0]    bd_bit,
    input  logic             bd_value
);

    inject_mode_e     inj_mode;
    logic             flip_true;
    logic             flip_shadow;
    logic             force_both;
    logic [WIDTH-1:0] true_word;
    logic [WIDTH-1:0] shadow_word;
    logic [AW-1:0]    rd_addr_q;

    assign inj_mode    = inject_mode_e'(bd_mode);
    assign flip_true   = bd_en && (inj_mode == INJ_FLIP_TRUE   || inj_mode == INJ_FLIP_BOTH);
    assign flip_shadow = bd_en && (inj_mode == INJ_FLIP_SHADOW || inj_mode == INJ_FLIP_BOTH);
    assign force_both  = bd_en && (inj_mode == INJ_FORCE_BOTH);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_addr_q <= '0;
        end else begin
            rd_valid <= req_en & ~req_we;
            if (req_en && !req_we) begin
                rd_addr_q <= req_addr;
            end
        end
    end

    tcr_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH), .STORE_INVERTED(1'b0)) u_true_bank (
        .clk       (clk),
        .acc_en    (req_en),
        .acc_we    (req_we),
        .acc_addr  (req_addr),
        .acc_wdata (req_wdata),
        .inj_flip  (flip_true),
        .inj_force (force_both),
        .inj_value (bd_value),
        .inj_addr  (bd_addr),
        .inj_bit   (bd_bit),
        .rd_word   (true_word)
    );

    tcr_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH), .STORE_INVERTED(1'b1)) u_shadow_bank (
        .clk       (clk),
        .acc_en    (req_en),
        .acc_we    (req_we),
        .acc_addr  (req_addr),
        .acc_wdata (req_wdata),
        .inj_flip  (flip_shadow),
        .inj_force (force_both),
        .inj_value (bd_value),
        .inj_addr  (bd_addr),
        .inj_bit   (bd_bit),
        .rd_word   (shadow_word)
    );

    tcr_compare #(.WIDTH(WIDTH)) u_compare (
        .true_word   (true_word),
        .shadow_word (shadow_word),
        .check_en    (rd_valid),
        .mismatch    (rd_mismatch)
    );

    tcr_trip_fsm #(.AW(AW)) u_trip (
        .clk        (clk),
        .rst_n      (rst_n),
        .chk_fail   (rd_mismatch),
        .chk_addr   (rd_addr_q),
        .clr        (switch_clr),
        .switch_req (switch_req),
        .fail_addr  (fail_addr)
    );

    assign rd_data = true_word;

endmodule

// File: rtl/tcr_checker.sv
module tcr_checker #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_en,
    input logic          req_we,
    input logic          rd_valid,
    input logic          rd_mismatch,
    input logic          switch_clr,
    input logic          switch_req,
    input logic [AW-1:0] fail_addr
);

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en && !req_we) |=> rd_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_en && !req_we) |=> !rd_valid);

    assert_flag_needs_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mismatch |-> rd_valid);

    assert_trip_on_mismatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mismatch |=> switch_req);

    assert_no_trip_without_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!switch_req && !rd_mismatch) |=> !switch_req);

    assert_sticky_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_req && !switch_clr) |=> switch_req);

    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_req && switch_clr && !rd_mismatch) |=> !switch_req);

    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_req && !switch_clr) |=> $stable(fail_addr));

    assert_retrip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_req && switch_clr && rd_mismatch) |=> switch_req);

endmodule

bind twin_complement_ram tcr_checker #(.AW(AW)) u_tcr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_en      (req_en),
    .req_we      (req_we),
    .rd_valid    (rd_valid),
    .rd_mismatch (rd_mismatch),
    .switch_clr  (switch_clr),
    .switch_req  (switch_req),
    .fail_addr   (fail_addr)
);

// File: tb/twin_complement_ram_bench.sv
`timescale 1ns/1ps
module twin_complement_ram_bench;

    localparam int W  = 16;
    localparam int D  = 64;
    localparam int AW = $clog2(D);
    localparam int BW = $clog2(W);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_en = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [W-1:0]  req_wdata = '0;
    logic [W-1:0]  rd_data;
    logic          rd_valid;
    logic          rd_mismatch;
    logic          switch_clr = 1'b0;
    logic          switch_req;
    logic [AW-1:0] fail_addr;
    logic          bd_en = 1'b0;
    logic [1:0]    bd_mode = 2'd0;
    logic [AW-1:0] bd_addr = '0;
    logic [BW-1:0] bd_bit = '0;
    logic          bd_value = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [W-1:0] img [D];

    always #2 clk = ~clk;

    twin_complement_ram #(.WIDTH(W), .DEPTH(D)) u_twin_complement_ram (
        .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_mismatch(rd_mismatch), .switch_clr(switch_clr),
        .switch_req(switch_req), .fail_addr(fail_addr), .bd_en(bd_en),
        .bd_mode(bd_mode), .bd_addr(bd_addr), .bd_bit(bd_bit), .bd_value(bd_value)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(input int p, input int a);
        logic [31:0] t;
        case (p)
            0:       t = a * 40503 + 23130;
            1:       t = ~(a * 40503 + 23130);
            2:       t = 32'h1 << (a % W);
            default: t = (a % 2 == 1) ? 32'hFFFF_FFFF : 32'h0;
        endcase
        return t[W-1:0];
    endfunction

    task automatic wr(input int a, input logic [W-1:0] d);
        req_en = 1'b1; req_we = 1'b1; req_addr = a[AW-1:0]; req_wdata = d;
        @(negedge clk);
        req_en = 1'b0; req_we = 1'b0;
        img[a] = d;
    endtask

    task automatic rd(input int a, output logic [W-1:0] d, output logic m, output logic v);
        req_en = 1'b1; req_we = 1'b0; req_addr = a[AW-1:0];
        @(negedge clk);
        req_en = 1'b0;
        d = rd_data; m = rd_mismatch; v = rd_valid;
    endtask

    task automatic inject(input int mode, input int a, input int b, input logic val);
        bd_en = 1'b1; bd_mode = mode[1:0]; bd_addr = a[AW-1:0]; bd_bit = b[BW-1:0]; bd_value = val;
        @(negedge clk);
        bd_en = 1'b0;
    endtask

    task automatic clear();
        switch_clr = 1'b1;
        @(negedge clk);
        switch_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] d;
        logic [W-1:0] held;
        logic m;
        logic v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check("R11 switch_req after reset", {31'b0, switch_req}, 32'd0);
        check("R11 fail_addr after reset", {26'b0, fail_addr}, 32'd0);
        check("R11 rd_valid after reset", {31'b0, rd_valid}, 32'd0);
        check("R11 rd_mismatch after reset", {31'b0, rd_mismatch}, 32'd0);

        // R1/R2: round trip for four data families over every address
        for (int p = 0; p < 4; p++) begin
            for (int a = 0; a < D; a++) wr(a, pat(p, a));
            for (int a = 0; a < D; a++) begin
                rd(a, d, m, v);
                check("R1 read data", {16'b0, d}, {16'b0, pat(p, a)});
                check("R1 no mismatch on clean word", {31'b0, m}, 32'd0);
                check("R2 valid one cycle after read", {31'b0, v}, 32'd1);
            end
            held = rd_data;
            @(negedge clk);
            check("R2 valid low when idle", {31'b0, rd_valid}, 32'd0);
            check("R2 data held when idle", {16'b0, rd_data}, {16'b0, held});
            check("R4 no request after clean reads", {31'b0, switch_req}, 32'd0);
        end

        // R5: clear in ARMED has no effect
        clear();
        check("R5 clear in ARMED", {31'b0, switch_req}, 32'd0);

        // R3/R4/R5: every bit position, true copy then shadow copy
        for (int sel = 0; sel < 2; sel++) begin
            for (int b = 0; b < W; b++) begin
                automatic int a = (b * 5 + sel * 7) % D;
                automatic logic [W-1:0] e = (sel == 0) ? (img[a] ^ (16'h1 << b)) : img[a];
                inject(sel, a, b, 1'b0);
                rd(a, d, m, v);
                check("R3 data follows true copy", {16'b0, d}, {16'b0, e});
                check("R3 single-bit mismatch flag", {31'b0, m}, 32'd1);
                @(negedge clk);
                check("R4 request raised", {31'b0, switch_req}, 32'd1);
                check("R4 failing address", {26'b0, fail_addr}, a);
                inject(sel, a, b, 1'b0);
                check("R5 request holds without clear", {31'b0, switch_req}, 32'd1);
                clear();
                check("R5 request released", {31'b0, switch_req}, 32'd0);
            end
        end

        // R6: first failing address is kept while tripped
        inject(0, 10, 3, 1'b0);
        inject(1, 20, 9, 1'b0);
        rd(10, d, m, v);
        rd(30, d, m, v);
        check("R6 clean read while tripped", {31'b0, m}, 32'd0);
        check("R6 request held", {31'b0, switch_req}, 32'd1);
        rd(20, d, m, v);
        check("R6 second fault flagged", {31'b0, m}, 32'd1);
        @(negedge clk);
        check("R6 first address kept", {26'b0, fail_addr}, 32'd10);

        // R7: clear together with a new mismatch re-trips at the new address
        rd(20, d, m, v);
        switch_clr = 1'b1;
        @(negedge clk);
        switch_clr = 1'b0;
        check("R7 request kept on clear with mismatch", {31'b0, switch_req}, 32'd1);
        check("R7 new failing address", {26'b0, fail_addr}, 32'd20);
        inject(0, 10, 3, 1'b0);
        inject(1, 20, 9, 1'b0);
        clear();
        check("R7 released after repair", {31'b0, switch_req}, 32'd0);

        // R8/R12: common-mode force at both levels, repaired by rewrite
        for (int lvl = 0; lvl < 2; lvl++) begin
            automatic int a = 40 + lvl;
            automatic int b = 6 + lvl * 5;
            automatic logic fv = (lvl == 0) ? img[a][b] : ~img[a][b];
            automatic logic [W-1:0] e = img[a];
            e[b] = fv;
            inject(2, a, b, fv);
            rd(a, d, m, v);
            check("R8 forced data", {16'b0, d}, {16'b0, e});
            check("R8 common-mode detected", {31'b0, m}, 32'd1);
            wr(a, img[a]);
            rd(a, d, m, v);
            check("R12 rewrite repairs data", {16'b0, d}, {16'b0, img[a]});
            check("R12 rewrite clears mismatch", {31'b0, m}, 32'd0);
            clear();
            check("R12 released", {31'b0, switch_req}, 32'd0);
        end

        // R9: flipping both copies keeps the complement relation
        inject(3, 50, 12, 1'b0);
        rd(50, d, m, v);
        check("R9 both-flip data", {16'b0, d}, {16'b0, img[50] ^ 16'h1000});
        check("R9 both-flip not flagged", {31'b0, m}, 32'd0);
        @(negedge clk);
        check("R9 no request", {31'b0, switch_req}, 32'd0);
        inject(3, 50, 12, 1'b0);

        // R10: injection colliding with a write to the same word is ignored
        req_en = 1'b1; req_we = 1'b1; req_addr = 6'd33; req_wdata = 16'hC3A5;
        bd_en = 1'b1; bd_mode = 2'd0; bd_addr = 6'd33; bd_bit = 4'd2; bd_value = 1'b0;
        @(negedge clk);
        req_en = 1'b0; req_we = 1'b0; bd_en = 1'b0;
        img[33] = 16'hC3A5;
        rd(33, d, m, v);
        check("R10 written word intact", {16'b0, d}, 32'h0000C3A5);
        check("R10 no mismatch after collision", {31'b0, m}, 32'd0);
        @(negedge clk);
        check("R10 no request after collision", {31'b0, switch_req}, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule